// File: doc/BRIEF.md
# Single-Error-Correcting Word Codec for 8-bit Memory Data

The codec protects each 8-bit memory word with four parity bits, forming a 12-bit stored codeword. The write path takes a data byte and produces the codeword to place in the array. The read path takes a codeword fetched from the array and recomputes its parity. It forms a 4-bit syndrome that gives the position of a single flipped bit. It inverts that bit and returns the repaired data byte. It also returns the repaired codeword, so the controller can store it back at the same address.

Codeword positions are numbered 1 to 12, and position p is codeword bit p-1. Parity bits sit at the power-of-two positions 1, 2, 4 and 8. The data bits fill the other positions in ascending order. Both paths are combinational. A parameter can add one register stage behind them. The data width is also a parameter, and the number of parity bits and the codeword width are derived from it.

Top module: `hsec_codec`

## Requirements
- R1: The data byte goes into the codeword as follows: data bit 0 at position 3, bit 1 at 5, bit 2 at 6, bit 3 at 7, bit 4 at 9, bit 5 at 10, bit 6 at 11 and bit 7 at 12. Position p is codeword bit p-1.
- R2: Each parity position 2^k holds the XOR of every data position whose number has bit k set. Position 1 covers 3,5,7,9,11. Position 2 covers 3,6,7,10,11. Position 4 covers 5,6,7,12. Position 8 covers 9,10,11,12.
- R3: A read of an unmodified codeword gives syndrome 0 and returns the original byte. The error, write-back and uncorrectable flags stay low, and the repaired codeword equals the input.
- R4: A read of a codeword with one flipped bit, at any position 1 to 12, gives a syndrome equal to that position. The original data byte is returned.
- R5: For any codeword the codec can correct, the repaired codeword output is the codeword the encoder makes for the returned data.
- R6: During a read, the error flag is high exactly when the syndrome is nonzero.
- R7: During a read, the write-back request is high exactly when the syndrome is in 1 to 12.
- R8: During a read, a syndrome above 12 raises the uncorrectable flag and lowers the write-back request. The codeword passes through unchanged, and the data is taken from its raw data positions.
- R9: When the read enable is low, the error, write-back and uncorrectable flags are all low, whatever codeword is presented.
- R10: With the output register enabled (the default), every output reflects the inputs one clock edge later. While reset is asserted, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Data byte to encode |
| wr_code | output | 12 | Encoded codeword for storage |
| rd_en | input | 1 | A read codeword is presented this cycle |
| rd_code | input | 12 | Codeword fetched from memory |
| rd_data | output | 8 | Repaired data byte |
| rd_fixed | output | 12 | Repaired codeword for write-back |
| rd_syndrome | output | 4 | Syndrome (position of the flipped bit, 0 if none) |
| rd_err | output | 1 | Nonzero syndrome on a read |
| rd_wb_req | output | 1 | Repaired word should be written back |
| rd_uncorr | output | 1 | Syndrome points outside the codeword |

## Verification
On every cycle, assertions check four things. Each encoded word has a zero syndrome. Each repaired word has a zero syndrome. A correction changes exactly one bit, and a clean or uncorrectable read changes none. The flags stay consistent with each other and stay low when no read is presented. The sweep over every byte, with every single-bit flip, is the only thing that shows the exact bit placement, the exact syndrome value and the recovered data against an independent encoder. Reset values, the one-cycle latency and double flips that push the syndrome past 12 are covered only by directed bench scenarios.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

   function automatic bit is_pow2(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // smallest parity count k with 2^k >= data + k + 1
   function automatic int chk_bits(int dw);
      for (int k = 1; k < 7; k++) begin
         if ((1 << k) >= dw + k + 1) return k;
      end
      return 7;
   endfunction

   // codeword position (1-based) of data bit j
   function automatic int data_pos(int j);
      int n;
      n = 0;
      for (int p = 1; p <= 64; p++) begin
         if (!is_pow2(p)) begin
            if (n == j) return p;
            n++;
         end
      end
      return 0;
   endfunction

   // positions whose number has bit k set; parity position itself optional
   function automatic logic [63:0] cover_mask(int k, int cw, bit with_chk);
      logic [63:0] m;
      m = '0;
      for (int p = 1; p <= cw; p++) begin
         if (((p >> k) & 1) == 1 && (with_chk || !is_pow2(p))) m[p-1] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/hsec_enc.sv
module hsec_enc #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = hsec_pkg::chk_bits(DATA_W),
   parameter int CW_W   = DATA_W + CHK_W
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   code
);
   logic [CW_W-1:0] placed;
   logic [CHK_W-1:0] par;

   // data scatter into non-power-of-two positions
   for (genvar j = 0; j < DATA_W; j++) begin : g_place
      localparam int POS = hsec_pkg::data_pos(j);
      assign placed[POS-1] = data[j];
   end
   for (genvar k = 0; k < CHK_W; k++) begin : g_hole
      assign placed[(1 << k) - 1] = 1'b0;
   end

   // parity over covered data positions
   for (genvar k = 0; k < CHK_W; k++) begin : g_par
      localparam logic [63:0] MASK = hsec_pkg::cover_mask(k, CW_W, 1'b0);
      assign par[k] = ^(placed & MASK[CW_W-1:0]);
   end

   always_comb begin
      code = placed;
      for (int k = 0; k < CHK_W; k++) code[(1 << k) - 1] = par[k];
   end
endmodule

// File: rtl/hsec_syn.sv
module hsec_syn #(
   parameter int CHK_W = 4,
   parameter int CW_W  = 12
) (
   input  logic [CW_W-1:0]  code,
   output logic [CHK_W-1:0] syn
);
   // recomputed parity XOR stored parity, folded into one reduction
   for (genvar k = 0; k < CHK_W; k++) begin : g_syn
      localparam logic [63:0] MASK = hsec_pkg::cover_mask(k, CW_W, 1'b1);
      assign syn[k] = ^(code & MASK[CW_W-1:0]);
   end
endmodule

// File: rtl/hsec_fix.sv
module hsec_fix #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW_W   = 12
) (
   input  logic [CW_W-1:0]   code,
   input  logic [CHK_W-1:0]  syn,
   output logic [CW_W-1:0]   fixed,
   output logic [DATA_W-1:0] data,
   output logic              err,
   output logic              uncorr
);
   logic [CW_W-1:0] flip;

   // one-hot position decode; out-of-range syndromes select nothing
   for (genvar p = 1; p <= CW_W; p++) begin : g_dec
      assign flip[p-1] = (syn == CHK_W'(p));
   end

   assign fixed  = code ^ flip;
   assign err    = |syn;
   assign uncorr = ({1'b0, syn} > (CHK_W+1)'(CW_W));

   for (genvar j = 0; j < DATA_W; j++) begin : g_take
      localparam int POS = hsec_pkg::data_pos(j);
      assign data[j] = fixed[POS-1];
   end

   // R8: an out-of-range syndrome decodes to no flip
   always_comb begin
      if (uncorr) a_r8_no_flip: assert (flip == '0);
   end
endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
   localparam int CW_W   = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CW_W-1:0]   wr_code,
   input  logic              rd_en,
   input  logic [CW_W-1:0]   rd_code,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW_W-1:0]   rd_fixed,
   output logic [CHK_W-1:0]  rd_syndrome,
   output logic              rd_err,
   output logic              rd_wb_req,
   output logic              rd_uncorr
);
   if (DATA_W < 1 || CW_W > 64) begin : g_bad_width
      $error("hsec_codec: DATA_W out of supported range");
   end

   logic [CW_W-1:0]   enc_c;
   logic [CHK_W-1:0]  syn_c;
   logic [CW_W-1:0]   fix_c;
   logic [DATA_W-1:0] dat_c;
   logic              err_c, unc_c;
   logic              err_g, wb_g, unc_g;

   hsec_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
      .data(wr_data), .code(enc_c));

   hsec_syn #(.CHK_W(CHK_W), .CW_W(CW_W)) u_syn (
      .code(rd_code), .syn(syn_c));

   hsec_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_fix (
      .code(rd_code), .syn(syn_c), .fixed(fix_c), .data(dat_c),
      .err(err_c), .uncorr(unc_c));

   assign err_g = rd_en & err_c;
   assign unc_g = rd_en & unc_c;
   assign wb_g  = rd_en & err_c & ~unc_c;

   logic [CW_W-1:0] raw_o;
   logic            vld_o;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_code     <= '0;
            rd_data     <= '0;
            rd_fixed    <= '0;
            rd_syndrome <= '0;
            rd_err      <= 1'b0;
            rd_wb_req   <= 1'b0;
            rd_uncorr   <= 1'b0;
            raw_o       <= '0;
            vld_o       <= 1'b0;
         end else begin
            wr_code     <= enc_c;
            rd_data     <= dat_c;
            rd_fixed    <= fix_c;
            rd_syndrome <= syn_c;
            rd_err      <= err_g;
            rd_wb_req   <= wb_g;
            rd_uncorr   <= unc_g;
            raw_o       <= rd_code;
            vld_o       <= rd_en;
         end
      end
   end else begin : g_comb
      assign wr_code     = enc_c;
      assign rd_data     = dat_c;
      assign rd_fixed    = fix_c;
      assign rd_syndrome = syn_c;
      assign rd_err      = err_g;
      assign rd_wb_req   = wb_g;
      assign rd_uncorr   = unc_g;
      assign raw_o       = rd_code;
      assign vld_o       = rd_en;
   end

   // independent syndrome units on the outputs, used only by the checks
   logic [CHK_W-1:0] enc_chk, fix_chk;
   hsec_syn #(.CHK_W(CHK_W), .CW_W(CW_W)) u_chk_enc (.code(wr_code),  .syn(enc_chk));
   hsec_syn #(.CHK_W(CHK_W), .CW_W(CW_W)) u_chk_fix (.code(rd_fixed), .syn(fix_chk));

   a_r2_enc_valid: assert property (@(posedge clk) disable iff (!rst_n)
      enc_chk == '0);
   a_r5_fixed_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !rd_uncorr) |-> fix_chk == '0);
   a_r3_clean_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !rd_err) |-> rd_fixed == raw_o);
   a_r4_one_bit_repair: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && rd_err && !rd_uncorr) |-> $countones(rd_fixed ^ raw_o) == 1);
   a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      rd_uncorr |-> (rd_err && !rd_wb_req && rd_fixed == raw_o));
   a_r7_wb_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wb_req |-> (rd_err && !rd_uncorr));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> !(rd_err || rd_wb_req || rd_uncorr));
endmodule

// File: tb/sim_hsec_codec.sv
module sim_hsec_codec;
   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n;
   logic [7:0]  wr_data;
   logic [11:0] wr_code;
   logic        rd_en;
   logic [11:0] rd_code;
   logic [7:0]  rd_data;
   logic [11:0] rd_fixed;
   logic [3:0]  rd_syndrome;
   logic        rd_err, rd_wb_req, rd_uncorr;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   hsec_codec u0 (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
      .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_data), .rd_fixed(rd_fixed),
      .rd_syndrome(rd_syndrome), .rd_err(rd_err), .rd_wb_req(rd_wb_req),
      .rd_uncorr(rd_uncorr));

   initial clk = 0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // independent reference encoder written from R1/R2
   function automatic logic [11:0] ref_enc(logic [7:0] d);
      logic [12:1] e;
      e = '0;
      e[3] = d[0]; e[5] = d[1]; e[6] = d[2]; e[7] = d[3];
      e[9] = d[4]; e[10] = d[5]; e[11] = d[6]; e[12] = d[7];
      e[1] = e[3] ^ e[5] ^ e[7] ^ e[9] ^ e[11];
      e[2] = e[3] ^ e[6] ^ e[7] ^ e[10] ^ e[11];
      e[4] = e[5] ^ e[6] ^ e[7] ^ e[12];
      e[8] = e[9] ^ e[10] ^ e[11] ^ e[12];
      return e;
   endfunction

   function automatic logic [7:0] raw_data(logic [11:0] c);
      return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
   endfunction

   task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // apply at a falling edge, result visible after the next rising edge
   task automatic apply(logic [7:0] d, logic en, logic [11:0] c);
      wr_data = d; rd_en = en; rd_code = c;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      rst_n = 0; wr_data = 8'hA5; rd_en = 1; rd_code = 12'hFFF;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(wr_code == 0 && rd_data == 0 && rd_fixed == 0, "R10 reset data", wr_code, 0);
      chk({rd_syndrome, rd_err, rd_wb_req, rd_uncorr} == 0, "R10 reset flags",
          {rd_syndrome, rd_err, rd_wb_req, rd_uncorr}, 0);
      rst_n = 1;
      @(negedge clk);

      // R10 latency: new input not visible before the edge
      apply(8'h00, 1'b1, ref_enc(8'h00));
      wr_data = 8'h3C; rd_code = ref_enc(8'h3C);
      #1;
      chk(wr_code == ref_enc(8'h00), "R10 holds until edge", wr_code, ref_enc(8'h00));
      @(negedge clk);
      chk(wr_code == ref_enc(8'h3C), "R10 after edge", wr_code, ref_enc(8'h3C));

      // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7
      for (int d = 0; d < 256; d++) begin
         for (int p = 0; p <= 12; p++) begin
            logic [11:0] good, sent;
            good = ref_enc(d[7:0]);
            sent = (p == 0) ? good : (good ^ (12'd1 << (p - 1)));
            apply(d[7:0], 1'b1, sent);
            chk(wr_code == good, "R1 R2 encode", wr_code, good);
            chk(rd_data == d[7:0], p == 0 ? "R3 clean data" : "R4 repaired data", rd_data, d);
            chk(rd_syndrome == p[3:0], "R4 syndrome", rd_syndrome, p);
            chk(rd_fixed == good, "R5 repaired word", rd_fixed, good);
            chk(rd_err == (p != 0), "R6 error flag", rd_err, p != 0);
            chk(rd_wb_req == (p != 0), "R7 write-back", rd_wb_req, p != 0);
            chk(rd_uncorr == 1'b0, "R8 no false uncorrectable", rd_uncorr, 0);
         end
      end

      // R8 double flips driving syndrome past 12
      begin
         int pa[3] = '{5, 6, 7};
         int pb[3] = '{8, 9, 8};
         for (int i = 0; i < 3; i++) begin
            logic [11:0] sent;
            logic [3:0]  s;
            sent = ref_enc(8'h5A) ^ (12'd1 << (pa[i]-1)) ^ (12'd1 << (pb[i]-1));
            s = 4'(pa[i] ^ pb[i]);
            apply(8'h5A, 1'b1, sent);
            chk(rd_syndrome == s, "R8 syndrome", rd_syndrome, s);
            chk(rd_uncorr && rd_err && !rd_wb_req, "R8 flags",
                {rd_uncorr, rd_err, rd_wb_req}, 3'b110);
            chk(rd_fixed == sent, "R8 word unchanged", rd_fixed, sent);
            chk(rd_data == raw_data(sent), "R8 raw data", rd_data, raw_data(sent));
         end
      end

      // R9 read enable low: flags stay low for corrupted and bad words
      for (int p = 1; p <= 12; p++) begin
         apply(8'hC3, 1'b0, ref_enc(8'hC3) ^ (12'd1 << (p - 1)));
         chk(!rd_err && !rd_wb_req && !rd_uncorr, "R9 idle flags",
             {rd_err, rd_wb_req, rd_uncorr}, 0);
      end
      apply(8'hC3, 1'b0, ref_enc(8'hC3) ^ 12'h090);
      chk(!rd_err && !rd_wb_req && !rd_uncorr, "R9 idle flags bad word",
          {rd_err, rd_wb_req, rd_uncorr}, 0);

      finish_run();
   end
endmodule